// File: doc/BRIEF.md
# Cycle-Steal DMA Channel

This block is one DMA channel that moves a programmed number of bytes between memory and a peripheral over a 32-bit bus master port. Software fills a small register set through a simple write port with a combinational read-back. The register set holds a control word, a source address, a destination address, a 16-bit byte counter and a status word. The peripheral then raises its request line once per unit of data. On each rising edge of that request the channel steals the bus for a single transfer.

A transfer takes one of two forms. In two-phase (dual-address) mode it reads from the source address into an internal latch, then writes to the destination address. Bytes and half-words are moved onto the byte lanes the destination address selects. In single-phase (single-address) mode only the source address is driven, always as a full 32-bit access, and the peripheral supplies or captures the data itself. Once the counter reaches zero the channel flags completion and can raise an interrupt.

Register offsets on `regAddr`: 0 control, 1 source address, 2 destination address, 3 byte count, 4 status.
- Control bits: [0] request enable, [1] interrupt enable, [2] memory-to-peripheral, [3] single-phase mode, [5:4] source size, [7:6] destination size.
- Size codes: 0 byte, 1 half-word, 2 word, 3 reserved.
- Status bits: [0] done, [1] configuration error, [2] busy.

Top module: `dma_channel`

## Requirements
- R1: In two-phase mode each accepted request produces a read beat at the source address (busWrite=0) followed by a write beat at the destination address (busWrite=1).
- R2: A read beat enables the lanes selected by the source address and size: byte lane = addr[1:0], half-word lanes = {addr[1],0} and +1, word all lanes. The written data repeats the latched byte or half-word across the bus, and busBe selects the lanes from the destination address in the same way.
- R3: After each transfer the incrementing address advances by 1, 2 or 4 per size. In two-phase memory-to-peripheral mode (control bit 2 = 1) the source advances and the destination holds. With bit 2 = 0 the destination advances and the source holds.
- R4: The byte counter resets to 0, decrements by the transfer size after each transfer, and reads back the remaining bytes at offset 3.
- R5: When a transfer brings the counter to zero, status bit 0 (done) sets. irq is high exactly when done is set and control bit 1 is set. After reset, status and irq read 0.
- R6: In single-phase mode (control bit 3) each request produces one beat at the source address with busBe=4'hF. busWrite is 1 for peripheral-to-memory and 0 for memory-to-peripheral. The source advances by 4 and the destination is unchanged.
- R7: A transfer starts only on a rising edge of dmaReq while control bit 0 is set. A request held high starts exactly one transfer.
- R8: Writing a nonzero count sets status bit 1 and blocks all transfers in these cases: the two size fields differ, the size is reserved, a single-phase size is not word, the source (or, in two-phase mode, the destination) is misaligned to the size, or the count is not a multiple of the size.
- R9: Writing status with bit 0 set clears done and the configuration error. It also aborts an in-flight transfer: busValid is low in the next cycle and the counter is unchanged.
- R10: While a transfer is in flight, writes to control, address and count registers are ignored.
- R11: busValid, busAddr and the phase hold until busReady is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| dmaReq | input | 1 | Peripheral transfer request |
| busValid | output | 1 | Bus beat valid |
| busWrite | output | 1 | Bus beat is a write |
| busAddr | output | 32 | Bus byte address |
| busBe | output | 4 | Byte-lane enables |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data, valid with busReady |
| busReady | input | 1 | Bus beat accepted |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume the following:
- The bus responder eventually raises busReady for every beat and returns read data in the same cycle.
- Software does not reprogram the channel while a transfer is being aborted.
- Only status writes arrive while the channel is busy, apart from the deliberate ignored-write case.

The stimulus keeps within this. A responder model answers every beat after a fixed, per-test number of wait cycles. All register writes and request edges come from tasks that wait out each transfer, except the abort and ignored-write scenarios, which issue their single write deliberately while a read beat is stalled.

// File: rtl/dma_pkg.sv
package dma_pkg;
  parameter int ADDR_W    = 32;
  parameter int CNT_W     = 16;
  parameter int REG_SEL_W = 3;
  parameter int LANES     = 4;

  localparam logic [REG_SEL_W-1:0] REG_CTRL   = 3'd0;
  localparam logic [REG_SEL_W-1:0] REG_SRC    = 3'd1;
  localparam logic [REG_SEL_W-1:0] REG_DST    = 3'd2;
  localparam logic [REG_SEL_W-1:0] REG_COUNT  = 3'd3;
  localparam logic [REG_SEL_W-1:0] REG_STATUS = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xferSize_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_SINGLE
  } phase_e;

  typedef struct packed {
    xferSize_e dstSize;
    xferSize_e srcSize;
    logic      single;
    logic      memToPeriph;
    logic      intEn;
    logic      reqEn;
  } ctrlWord_t;

  typedef struct packed {
    logic latchData;
    logic advance;
    logic abort;
  } strobe_t;

  function automatic logic [2:0] stepOf(input xferSize_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic misaligned(input logic [1:0] lo, input xferSize_e sz);
    case (sz)
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dma_lane_align.sv
module dma_lane_align
  import dma_pkg::*;
(
  input  xferSize_e           sizeSel,
  input  logic [1:0]          laneAddr,
  input  logic [8*LANES-1:0]  rdata,
  input  logic [8*LANES-1:0]  latchVal,
  output logic [8*LANES-1:0]  rdAligned,
  output logic [8*LANES-1:0]  wdata,
  output logic [LANES-1:0]    be
);
  localparam int DATA_W = 8 * LANES;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] LANE_IDX = 2'(i);
    assign be[i] = (sizeSel == SZ_WORD) ||
                   (sizeSel == SZ_HALF && laneAddr[1] == LANE_IDX[1]) ||
                   (sizeSel == SZ_BYTE && laneAddr == LANE_IDX);
  end

  always_comb begin
    rdAligned = '0;
    wdata     = latchVal;
    case (sizeSel)
      SZ_BYTE: begin
        rdAligned[7:0] = rdata[{laneAddr, 3'b000} +: 8];
        wdata          = {LANES{latchVal[7:0]}};
      end
      SZ_HALF: begin
        rdAligned[15:0] = rdata[{laneAddr[1], 4'b0000} +: 16];
        wdata           = {(LANES/2){latchVal[15:0]}};
      end
      default: begin
        rdAligned = rdata[DATA_W-1:0];
        wdata     = latchVal;
      end
    endcase
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dmaReq,
  input  logic    reqEn,
  input  logic    single,
  input  logic    memToPeriph,
  input  logic    armed,
  input  logic    abortReq,
  input  logic    busReady,
  output phase_e  phase,
  output logic    busy,
  output logic    busValid,
  output logic    busWrite,
  output strobe_t strb
);
  phase_e phaseNext;
  logic   reqPrev;
  logic   reqRise;

  assign reqRise = dmaReq && !reqPrev;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:
        if (!abortReq && reqEn && armed && reqRise)
          phaseNext = single ? PH_SINGLE : PH_READ;
      PH_READ:
        if (abortReq)      phaseNext = PH_IDLE;
        else if (busReady) phaseNext = PH_WRITE;
      default:
        if (abortReq || busReady) phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      reqPrev <= 1'b0;
    end else begin
      phase   <= phaseNext;
      reqPrev <= dmaReq;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign busValid = busy;
  assign busWrite = (phase == PH_WRITE) || (phase == PH_SINGLE && !memToPeriph);

  always_comb begin
    strb.abort     = abortReq;
    strb.latchData = (phase == PH_READ) && busReady && !abortReq;
    strb.advance   = (phase == PH_WRITE || phase == PH_SINGLE) && busReady && !abortReq;
  end

  p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady && !abortReq |=> busValid && phase == $past(phase));

  p_write_follows_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_WRITE && $past(phase) != PH_WRITE |-> $past(phase) == PH_READ);

  p_no_start_unarmed_r8: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE && !(armed && reqEn) |=> phase == PH_IDLE);

  p_held_req_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE && dmaReq && reqPrev |=> phase == PH_IDLE);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 busy,
  input  phase_e               phase,
  input  strobe_t              strb,
  input  logic [8*LANES-1:0]   busRdata,
  output ctrlWord_t            ctrlReg,
  output logic                 armed,
  output logic                 abortReq,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [LANES-1:0]     busBe,
  output logic [8*LANES-1:0]   busWdata,
  output logic                 irq
);
  localparam int DATA_W = 8 * LANES;

  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [CNT_W-1:0]  count;
  logic              done, cfgErr;
  logic [DATA_W-1:0] latchReg;

  logic              writeOk, cfgBad;
  logic [2:0]        step;
  logic [CNT_W-1:0]  newCount;
  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] stepAddr;
  xferSize_e         laneSize;
  logic [1:0]        laneAddr;
  logic [DATA_W-1:0] rdAligned, laneWdata;
  logic [LANES-1:0]  laneBe;

  assign step     = stepOf(ctrlReg.srcSize);
  assign stepCnt  = {{(CNT_W-3){1'b0}}, step};
  assign stepAddr = {{(ADDR_W-3){1'b0}}, step};
  assign newCount = regWdata[CNT_W-1:0];
  assign writeOk  = regWr && !busy;
  assign abortReq = regWr && (regAddr == REG_STATUS) && regWdata[0];
  assign armed    = (count != '0) && !cfgErr && !done;
  assign irq      = done && ctrlReg.intEn;

  always_comb begin
    cfgBad = 1'b0;
    if (newCount != '0) begin
      cfgBad = (ctrlReg.srcSize != ctrlReg.dstSize) ||
               (ctrlReg.srcSize == SZ_RSVD) ||
               (ctrlReg.single && ctrlReg.srcSize != SZ_WORD) ||
               misaligned(srcAddr[1:0], ctrlReg.srcSize) ||
               (!ctrlReg.single && misaligned(dstAddr[1:0], ctrlReg.dstSize)) ||
               misaligned(newCount[1:0], ctrlReg.srcSize);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      srcAddr  <= '0;
      dstAddr  <= '0;
      count    <= '0;
      done     <= 1'b0;
      cfgErr   <= 1'b0;
      latchReg <= '0;
    end else begin
      if (abortReq) begin
        done   <= 1'b0;
        cfgErr <= 1'b0;
      end
      if (writeOk) begin
        case (regAddr)
          REG_CTRL:  ctrlReg <= ctrlWord_t'(regWdata[7:0]);
          REG_SRC:   srcAddr <= regWdata[ADDR_W-1:0];
          REG_DST:   dstAddr <= regWdata[ADDR_W-1:0];
          REG_COUNT: begin
            count <= newCount;
            if (cfgBad) cfgErr <= 1'b1;
          end
          default: ;
        endcase
      end
      if (strb.latchData) latchReg <= rdAligned;
      if (strb.advance) begin
        count <= count - stepCnt;
        if (ctrlReg.single || ctrlReg.memToPeriph) srcAddr <= srcAddr + stepAddr;
        else                                       dstAddr <= dstAddr + stepAddr;
        if (count == stepCnt) done <= 1'b1;
      end
    end
  end

  assign laneSize = (phase == PH_WRITE) ? ctrlReg.dstSize : ctrlReg.srcSize;
  assign laneAddr = (phase == PH_WRITE) ? dstAddr[1:0] : srcAddr[1:0];

  dma_lane_align u_lane (
    .sizeSel   (laneSize),
    .laneAddr  (laneAddr),
    .rdata     (busRdata),
    .latchVal  (latchReg),
    .rdAligned (rdAligned),
    .wdata     (laneWdata),
    .be        (laneBe)
  );

  assign busAddr  = (phase == PH_WRITE) ? dstAddr : srcAddr;
  assign busBe    = (phase == PH_SINGLE) ? {LANES{1'b1}} : laneBe;
  assign busWdata = (phase == PH_WRITE) ? laneWdata : '0;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CTRL:   regRdata[7:0]        = ctrlReg;
      REG_SRC:    regRdata             = srcAddr;
      REG_DST:    regRdata             = dstAddr;
      REG_COUNT:  regRdata[CNT_W-1:0]  = count;
      REG_STATUS: regRdata[2:0]        = {busy, cfgErr, done};
      default:    ;
    endcase
  end

  p_count_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> count >= stepCnt);

  p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && count == stepCnt |=> done && count == '0);

  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_READ && regWr && regAddr == REG_SRC |=> srcAddr == $past(srcAddr));

  p_src_fixed_inbound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !ctrlReg.single && !ctrlReg.memToPeriph |=> srcAddr == $past(srcAddr));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 dmaReq,
  output logic                 busValid,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [LANES-1:0]     busBe,
  output logic [8*LANES-1:0]   busWdata,
  input  logic [8*LANES-1:0]   busRdata,
  input  logic                 busReady,
  output logic                 irq
);
  ctrlWord_t ctrlReg;
  strobe_t   strb;
  phase_e    phase;
  logic      busy, armed, abortReq;

  dma_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .dmaReq      (dmaReq),
    .reqEn       (ctrlReg.reqEn),
    .single      (ctrlReg.single),
    .memToPeriph (ctrlReg.memToPeriph),
    .armed       (armed),
    .abortReq    (abortReq),
    .busReady    (busReady),
    .phase       (phase),
    .busy        (busy),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .strb        (strb)
  );

  dma_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busy),
    .phase    (phase),
    .strb     (strb),
    .busRdata (busRdata),
    .ctrlReg  (ctrlReg),
    .armed    (armed),
    .abortReq (abortReq),
    .busAddr  (busAddr),
    .busBe    (busBe),
    .busWdata (busWdata),
    .irq      (irq)
  );
endmodule

// File: tb/tb_dma_channel.sv
module tb_dma_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        dmaReq = 1'b0;
  logic        busValid, busWrite;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [3:0]  busBe;
  logic        busReady = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int waitCycles = 0;
  int wcnt = 0;
  bit finished = 1'b0;

  logic [31:0] logAddr  [0:63];
  logic [31:0] logWdata [0:63];
  logic [3:0]  logBe    [0:63];
  logic        logWr    [0:63];
  int logN = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_channel dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .dmaReq(dmaReq), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .irq(irq)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] rdWord(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {pat(b + 3), pat(b + 2), pat(b + 1), pat(b)};
  endfunction

  always_comb busRdata = rdWord(busAddr);

  always @(negedge clk) begin
    if (busReady) begin
      busReady = 1'b0;
      wcnt = 0;
    end else if (busValid) begin
      if (wcnt >= waitCycles) busReady = 1'b1;
      else wcnt++;
    end else begin
      wcnt = 0;
    end
  end

  always @(posedge clk) begin
    if (rstN && busValid && busReady && logN < 64) begin
      logAddr[logN]  <= busAddr;
      logWdata[logN] <= busWdata;
      logBe[logN]    <= busBe;
      logWr[logN]    <= busWrite;
      logN           <= logN + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseReq();
    @(negedge clk); dmaReq = 1'b1;
    @(negedge clk); dmaReq = 1'b0;
  endtask

  task automatic settle();
    repeat (20 + 4 * waitCycles) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] c, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    regWrite(3'd4, 32'h1);
    regWrite(3'd0, {24'h0, c});
    regWrite(3'd1, s);
    regWrite(3'd2, d);
    regWrite(3'd3, n);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(3'd4, v); chk("R5", "status after reset", v, 32'h0);
    regRead(3'd3, v); chk("R4", "count after reset", v, 32'h0);
    chk("R5", "irq after reset", {31'h0, irq}, 32'h0);
    chk("R11", "busValid after reset", {31'h0, busValid}, 32'h0);
  endtask

  task automatic testByteOutbound();
    logic [31:0] v;
    int base;
    setup(8'h07, 32'h101, 32'h2002, 32'd3);
    for (int k = 0; k < 3; k++) begin
      base = logN;
      @(negedge clk); dmaReq = 1'b1;
      repeat (20) @(negedge clk);
      dmaReq = 1'b0;
      settle();
      chk("R7", "beats per held request", logN - base, 2);
      chk("R1", "read beat direction", {31'h0, logWr[base]}, 32'h0);
      chk("R1", "read beat address", logAddr[base], 32'h101 + k);
      chk("R2", "read lane enable", {28'h0, logBe[base]}, 32'h1 << ((1 + k) & 3));
      chk("R1", "write beat direction", {31'h0, logWr[base+1]}, 32'h1);
      chk("R3", "fixed destination", logAddr[base+1], 32'h2002);
      chk("R2", "write lane enable", {28'h0, logBe[base+1]}, 32'h4);
      chk("R2", "write lane data", {24'h0, logWdata[base+1][23:16]}, {24'h0, pat(32'h101 + k)});
      regRead(3'd3, v); chk("R4", "residue", v, 32'd2 - k);
      regRead(3'd1, v); chk("R3", "source advanced", v, 32'h102 + k);
    end
    regRead(3'd4, v); chk("R5", "done set", v, 32'h1);
    chk("R5", "irq with enable", {31'h0, irq}, 32'h1);
  endtask

  task automatic testHalfInbound();
    logic [31:0] v;
    int base;
    waitCycles = 2;
    base = logN;
    setup(8'h51, 32'h3000, 32'h4002, 32'd4);
    pulseReq(); settle();
    pulseReq(); settle();
    chk("R11", "beats under wait states", logN - base, 4);
    chk("R2", "half read enable", {28'h0, logBe[base]}, 32'h3);
    chk("R2", "upper half write enable", {28'h0, logBe[base+1]}, 32'hC);
    chk("R2", "upper half data", {16'h0, logWdata[base+1][31:16]}, {16'h0, pat(32'h3001), pat(32'h3000)});
    chk("R3", "second write address", logAddr[base+3], 32'h4004);
    chk("R2", "lower half write enable", {28'h0, logBe[base+3]}, 32'h3);
    chk("R2", "lower half data", {16'h0, logWdata[base+3][15:0]}, {16'h0, pat(32'h3001), pat(32'h3000)});
    regRead(3'd1, v); chk("R3", "inbound source held", v, 32'h3000);
    regRead(3'd2, v); chk("R3", "inbound destination advanced", v, 32'h4006);
    regRead(3'd4, v); chk("R5", "done without irq enable", v, 32'h1);
    chk("R5", "irq masked", {31'h0, irq}, 32'h0);
    waitCycles = 0;
  endtask

  task automatic testWord();
    logic [31:0] v;
    int base;
    base = logN;
    setup(8'hA5, 32'h500, 32'h600, 32'd8);
    pulseReq(); settle();
    pulseReq(); settle();
    chk("R1", "word beats", logN - base, 4);
    chk("R2", "word data 0", logWdata[base+1], rdWord(32'h500));
    chk("R2", "word data 1", logWdata[base+3], rdWord(32'h504));
    chk("R2", "word enable", {28'h0, logBe[base+3]}, 32'hF);
    regRead(3'd1, v); chk("R3", "word source step", v, 32'h508);
    regRead(3'd3, v); chk("R4", "word residue zero", v, 32'h0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    int base;
    base = logN;
    setup(8'hA9, 32'h700, 32'h900, 32'd8);
    pulseReq(); settle();
    pulseReq(); settle();
    chk("R6", "single beats", logN - base, 2);
    chk("R6", "single write dir", {31'h0, logWr[base]}, 32'h1);
    chk("R6", "single enable", {28'h0, logBe[base+1]}, 32'hF);
    chk("R6", "single second address", logAddr[base+1], 32'h704);
    regRead(3'd2, v); chk("R6", "single dest untouched", v, 32'h900);
    regRead(3'd1, v); chk("R6", "single source", v, 32'h708);
    base = logN;
    setup(8'hAD, 32'h800, 32'h900, 32'd4);
    pulseReq(); settle();
    chk("R6", "single outbound beats", logN - base, 1);
    chk("R6", "single outbound read dir", {31'h0, logWr[base]}, 32'h0);
  endtask

  task automatic testGate();
    logic [31:0] v;
    int base;
    base = logN;
    setup(8'hA4, 32'hA00, 32'hB00, 32'd4);
    pulseReq(); settle();
    chk("R7", "no beats while disabled", logN - base, 0);
    regRead(3'd3, v); chk("R7", "count kept while disabled", v, 32'd4);
    regWrite(3'd0, 32'hA5);
    pulseReq(); settle();
    chk("R7", "beats once enabled", logN - base, 2);
  endtask

  task automatic cfgCase(input string what, input logic [7:0] c, input logic [31:0] s, input logic [31:0] n);
    logic [31:0] v;
    int base;
    base = logN;
    setup(c, s, 32'h900, n);
    regRead(3'd4, v); chk("R8", what, v, 32'h2);
    pulseReq(); settle();
    chk("R8", "blocked transfer", logN - base, 0);
  endtask

  task automatic testCfg();
    logic [31:0] v;
    cfgCase("misaligned source", 8'h55, 32'h801, 32'd2);
    cfgCase("size mismatch", 8'h95, 32'h800, 32'd4);
    cfgCase("single not word", 8'h09, 32'h800, 32'd4);
    cfgCase("count not multiple", 8'h55, 32'h800, 32'd3);
    regWrite(3'd4, 32'h1);
    regRead(3'd4, v); chk("R9", "error cleared", v, 32'h0);
  endtask

  task automatic testAbort();
    logic [31:0] v;
    int base;
    waitCycles = 10;
    setup(8'hA5, 32'hC00, 32'hD00, 32'd8);
    base = logN;
    pulseReq();
    regWrite(3'd4, 32'h1);
    chk("R9", "busValid after abort", {31'h0, busValid}, 32'h0);
    settle();
    chk("R9", "no beats after abort", logN - base, 0);
    regRead(3'd3, v); chk("R9", "count after abort", v, 32'd8);
    waitCycles = 0;
    pulseReq(); settle();
    chk("R9", "restart after abort", logAddr[base], 32'hC00);
  endtask

  task automatic testBusyWrite();
    logic [31:0] v;
    waitCycles = 6;
    setup(8'hA5, 32'hE00, 32'hF00, 32'd8);
    pulseReq();
    regWrite(3'd1, 32'h1234);
    settle();
    regRead(3'd1, v); chk("R10", "source write ignored while busy", v, 32'hE04);
    waitCycles = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testByteOutbound();
    testHalfInbound();
    testWord();
    testSingle();
    testGate();
    testCfg();
    testAbort();
    testBusyWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule